// File: doc/BRIEF.md
# Dual-Divider Countdown Timer

A countdown timer with its own register bank on a simple single-cycle register bus. The main counter decrements once per prescaled tick. The tick period is the product of a programmable pre-divider and a fixed scale of 1, 16 or 256, chosen in the control word. The counter works on 16 or 32 bits. When it decrements from one to zero it flags an interrupt. After that it either reloads from a background reload value, holds at zero, or wraps to all ones, depending on the mode bits.

A second, independent free-running counter advances once every (divider+1) system clocks while it is enabled. Its 8-bit divider sits in the control word. A debug-halt input can freeze the countdown path when a control bit allows it. Reads are combinational from the byte offset on `bus_addr`. Writes take effect at the rising clock edge on which `bus_wr` is high.

Top module: `dual_div_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: A write to offset 0x00 sets both the current count (read at 0x04) and the reload value (read at 0x00 and 0x18). A write to 0x18 changes only the reload value.
- R3: With control bit 7 set, the count decrements once every (D+1)*S clocks. D is the pre-divider at offset 0x1C, which keeps its low 8 bits. S comes from control bits 3:2: 0 gives 1, 1 gives 16, 2 or 3 gives 256. The first decrement lands (D+1)*S edges after the enabling write.
- R4: A decrement from 1 to 0 sets the raw interrupt flag, read at 0x10 bit 0.
- R5: In periodic mode (bit 6 set, bit 0 clear), the tick after reaching zero loads the reload value.
- R6: In one-shot mode (bit 0 set, which takes priority over bit 6), the count stays at zero.
- R7: With bits 0 and 6 both clear, the tick after zero wraps the count to all ones of the active width.
- R8: With control bit 1 clear, only the low 16 bits count and read back. With bit 1 set, all 32 bits do.
- R9: The masked flag at 0x14 bit 0 and `irq_o` both equal the raw flag ANDed with control bit 5.
- R10: Any write to 0x0C clears the raw flag.
- R11: While `dbg_halt_i` is high and control bit 8 is set, the count and prescaler freeze. With bit 8 clear, `dbg_halt_i` has no effect.
- R12: With control bit 9 set, the free counter at 0x20 increments once every (F+1) clocks, where F is control bits 23:16. With bit 9 clear it holds.
- R13: Writes to 0x04, 0x10, 0x14 and 0x20 are ignored. Control bits outside 0-3, 5-9 and 16-23 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench sweeps width, scale, pre-divider and start count. It predicts the exact edge of the first decrement and of the zero crossing from (D+1)*S. An off-by-one in the tick counter or the zero test would move the interrupt a tick early or late. Each mode's behaviour after zero is checked at its own tick. A design that confused one-shot priority, or the 16-bit wrap value, would read back a reload value or 0xFFFFFFFF where 0 or 0xFFFF is expected. The bench also checks that a reload write leaves the live count alone and that a debug halt without its enable bit keeps counting.

// File: rtl/tmr_pkg.sv
`timescale 1ns/10ps
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int FDIV_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LOAD   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_VALUE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_MSK    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_PREDIV = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_FREE   = 6'h20;

  // control word bit positions
  localparam int B_ONESHOT  = 0;
  localparam int B_WIDE     = 1;
  localparam int B_SCALE    = 2;
  localparam int B_IE       = 5;
  localparam int B_PERIODIC = 6;
  localparam int B_EN       = 7;
  localparam int B_DBGHALT  = 8;
  localparam int B_FREE_EN  = 9;
  localparam int B_FDIV     = 16;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_03EF;

  function automatic logic [31:0] scale_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd1;
      2'd1:    return 32'd16;
      default: return 32'd256;
    endcase
  endfunction

  // terminal value of the prescale counter: (pre+1)*scale - 1
  function automatic logic [31:0] tick_limit(input logic [31:0] pre, input logic [1:0] sel);
    return (pre + 32'd1) * scale_of(sel) - 32'd1;
  endfunction

  function automatic logic [31:0] width_mask(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/10ps
module tmr_tick_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_down.sv
`timescale 1ns/10ps
module tmr_down
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              wide,
  input  logic              oneshot,
  input  logic              periodic,
  output logic [DATA_W-1:0] value,
  output logic              hit_zero
);
  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] mask;
  logic              at_zero;

  assign mask     = width_mask(wide);
  assign value    = cur_q & mask;
  assign at_zero  = (value == '0);
  assign hit_zero = tick && !load_wr && (value == 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_q <= '0;
    else if (load_wr)   cur_q <= load_val;
    else if (tick) begin
      if (!at_zero)     cur_q <= value - 32'd1;
      else if (oneshot) cur_q <= cur_q;
      else if (periodic) cur_q <= reload_val;
      else              cur_q <= mask;
    end
  end
endmodule

// File: rtl/dual_div_timer.sv
`timescale 1ns/10ps
module dual_div_timer
  import tmr_pkg::*;
#(
  parameter int PREDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt_i,
  output logic              irq_o
);
  localparam int LIM_W = PREDIV_W + 9;

  logic [DATA_W-1:0]   ctrl_q, reload_q, free_q, value;
  logic [PREDIV_W-1:0] prediv_q;
  logic                raw_q;

  // named events for the checker
  logic wr_load, wr_reload, wr_ctrl, wr_clr, wr_prediv;
  logic tmr_en, halt_en, ie_en, oneshot_m, periodic_m, wide_m, free_en;
  logic halted, pre_tick, free_tick, hit_zero;
  logic [LIM_W-1:0]  pre_limit;
  logic [FDIV_W-1:0] free_limit;

  assign wr_load   = bus_wr && (bus_addr == OFS_LOAD);
  assign wr_reload = bus_wr && (bus_addr == OFS_RELOAD);
  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_clr    = bus_wr && (bus_addr == OFS_CLR);
  assign wr_prediv = bus_wr && (bus_addr == OFS_PREDIV);

  assign tmr_en     = ctrl_q[B_EN];
  assign halt_en    = ctrl_q[B_DBGHALT];
  assign ie_en      = ctrl_q[B_IE];
  assign oneshot_m  = ctrl_q[B_ONESHOT];
  assign periodic_m = ctrl_q[B_PERIODIC];
  assign wide_m     = ctrl_q[B_WIDE];
  assign free_en    = ctrl_q[B_FREE_EN];
  assign halted     = dbg_halt_i && halt_en;

  assign pre_limit  = LIM_W'(tick_limit(32'(prediv_q), ctrl_q[B_SCALE +: 2]));
  assign free_limit = ctrl_q[B_FDIV +: FDIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      prediv_q <= '0;
      raw_q    <= 1'b0;
      free_q   <= '0;
    end else begin
      if (wr_ctrl)               ctrl_q   <= bus_wdata & CTRL_MASK;
      if (wr_load || wr_reload)  reload_q <= bus_wdata;
      if (wr_prediv)             prediv_q <= bus_wdata[PREDIV_W-1:0];
      if (hit_zero)              raw_q    <= 1'b1;
      else if (wr_clr)           raw_q    <= 1'b0;
      if (free_tick)             free_q   <= free_q + 32'd1;
    end
  end

  tmr_tick_gen #(.W(LIM_W)) u_prescale (
    .clk(clk), .rst_n(rst_n),
    .run(tmr_en && !halted), .restart(!tmr_en || wr_load),
    .limit(pre_limit), .tick(pre_tick)
  );

  tmr_tick_gen #(.W(FDIV_W)) u_free_div (
    .clk(clk), .rst_n(rst_n),
    .run(free_en), .restart(!free_en),
    .limit(free_limit), .tick(free_tick)
  );

  tmr_down u_down (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick),
    .load_wr(wr_load), .load_val(bus_wdata), .reload_val(reload_q),
    .wide(wide_m), .oneshot(oneshot_m), .periodic(periodic_m),
    .value(value), .hit_zero(hit_zero)
  );

  assign irq_o = raw_q && ie_en;

  always_comb begin
    case (bus_addr)
      OFS_LOAD, OFS_RELOAD: bus_rdata = reload_q;
      OFS_VALUE:            bus_rdata = value;
      OFS_CTRL:             bus_rdata = ctrl_q;
      OFS_RAW:              bus_rdata = {31'b0, raw_q};
      OFS_MSK:              bus_rdata = {31'b0, irq_o};
      OFS_PREDIV:           bus_rdata = 32'(prediv_q);
      OFS_FREE:             bus_rdata = free_q;
      default:              bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_div_timer_chk.sv
`timescale 1ns/10ps
module dual_div_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbg_halt_i,
  input logic        halt_en,
  input logic        tmr_en,
  input logic        pre_tick,
  input logic        hit_zero,
  input logic        raw_q,
  input logic        irq_o,
  input logic        ie_en,
  input logic        oneshot_m,
  input logic        wr_load,
  input logic        wr_ctrl,
  input logic        wr_clr,
  input logic        free_en,
  input logic [31:0] value,
  input logic [31:0] free_q
);
  assert_tick_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (tmr_en && !(dbg_halt_i && halt_en)));

  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt_i && halt_en && !wr_load && !wr_ctrl) |=> $stable(value));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_q && ie_en));

  assert_raw_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(hit_zero));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !hit_zero) |=> !raw_q);

  assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_m && value == 32'd0 && !wr_load && !wr_ctrl) |=> (value == 32'd0));

  assert_free_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |=> $stable(free_q));
endmodule

bind dual_div_timer dual_div_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i), .halt_en(halt_en),
  .tmr_en(tmr_en), .pre_tick(pre_tick), .hit_zero(hit_zero), .raw_q(raw_q),
  .irq_o(irq_o), .ie_en(ie_en), .oneshot_m(oneshot_m), .wr_load(wr_load),
  .wr_ctrl(wr_ctrl), .wr_clr(wr_clr), .free_en(free_en), .value(value),
  .free_q(free_q)
);

// File: tb/dual_div_timer_bench.sv
`timescale 1ns/10ps
module dual_div_timer_bench;
  localparam logic [5:0] A_LOAD = 6'h00, A_VAL = 6'h04, A_CTRL = 6'h08, A_CLR = 6'h0C,
                         A_RAW = 6'h10, A_MSK = 6'h14, A_REL = 6'h18, A_PRE = 6'h1C,
                         A_FREE = 6'h20;
  localparam logic [31:0] K_ONE = 32'h1, K_WIDE = 32'h2, K_IE = 32'h20, K_PER = 32'h40,
                          K_EN = 32'h80, K_HALT = 32'h100, K_FREE = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt_i = 1'b0;
  logic        irq_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_div_timer u_dual_div_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt_i(dbg_halt_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end in the low phase just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #0.5 bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #0.1 d = bus_rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    if (k > 0) @(negedge clk);
  endtask

  task automatic quiet();
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, base, f1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      peek(6'(a * 4), r);
      chk("R1 reset register", r, 32'h0);
    end
    chk("R1 irq_o after reset", 32'(irq_o), 32'h0);

    // R2 load vs reload
    wr(A_LOAD, 32'd5);
    peek(A_VAL, r); chk("R2 load sets count", r, 32'd5);
    peek(A_REL, r); chk("R2 load sets reload", r, 32'd5);
    wr(A_REL, 32'd9);
    peek(A_VAL, r); chk("R2 reload leaves count", r, 32'd5);
    peek(A_LOAD, r); chk("R2 reload readback", r, 32'd9);

    // R13 ignored writes and control mask
    wr(A_VAL, 32'h77);   peek(A_VAL, r);  chk("R13 value write ignored", r, 32'd5);
    wr(A_FREE, 32'h55);  peek(A_FREE, r); chk("R13 free write ignored", r, 32'h0);
    wr(A_RAW, 32'h1);    peek(A_RAW, r);  chk("R13 raw write ignored", r, 32'h0);
    wr(A_MSK, 32'h1);    peek(A_MSK, r);  chk("R13 masked write ignored", r, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, r); chk("R13 control mask", r, 32'h00FF_03EF);
    quiet();

    // R3 pre-divider width
    wr(A_PRE, 32'h1A5); peek(A_PRE, r); chk("R3 prediv keeps 8 bits", r, 32'hA5);

    // R8 width readback
    wr(A_LOAD, 32'h0001_2345);
    peek(A_VAL, r); chk("R8 16-bit readback", r, 32'h2345);
    wr(A_CTRL, K_WIDE);
    peek(A_VAL, r); chk("R8 32-bit readback", r, 32'h0001_2345);
    quiet();

    // R3 R4 R5 R8 R9 sweep of width, scale, pre-divider, start count
    for (int w = 0; w < 2; w++)
      for (int sel = 0; sel < 3; sel++)
        for (int pd = 0; pd < 3; pd += 2)
          for (int n = 2; n <= 3; n++) begin
            int p;
            if (sel == 2 && pd != 0) continue;
            p = (pd + 1) * (sel == 0 ? 1 : (sel == 1 ? 16 : 256));
            quiet();
            wr(A_PRE, 32'(pd));
            wr(A_LOAD, (w == 1) ? (32'h0001_0000 | 32'(n)) : (32'hABCD_0000 | 32'(n)));
            wr(A_REL, 32'(n + 4));
            wr(A_CTRL, K_EN | K_IE | K_PER | (w == 1 ? K_WIDE : 32'h0) | 32'(sel << 2));
            edges(p - 1);
            peek(A_VAL, r);
            chk("R3 R8 before first tick", r, (w == 1) ? (32'h0001_0000 | 32'(n)) : 32'(n));
            edges(1);
            peek(A_VAL, r);
            chk("R3 R8 first tick", r, (w == 1) ? (32'h0001_0000 | 32'(n - 1)) : 32'(n - 1));
            if (w == 0) begin
              edges((n - 1) * p - 1);
              peek(A_RAW, r); chk("R4 raw before zero", r, 32'h0);
              edges(1);
              peek(A_RAW, r); chk("R4 raw at zero", r, 32'h1);
              peek(A_VAL, r); chk("R4 count at zero", r, 32'h0);
              peek(A_MSK, r); chk("R9 masked with enable", r, 32'h1);
              chk("R9 irq_o with enable", 32'(irq_o), 32'h1);
              edges(p);
              peek(A_VAL, r); chk("R5 periodic reload", r, 32'(n + 4));
            end
          end
    quiet();
    wr(A_PRE, 32'h0);

    // R6 one-shot priority over periodic
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, K_EN | K_ONE | K_PER | K_IE);
    edges(2);
    peek(A_VAL, r); chk("R6 one-shot reaches zero", r, 32'h0);
    peek(A_RAW, r); chk("R4 one-shot raw", r, 32'h1);
    edges(5);
    peek(A_VAL, r); chk("R6 one-shot holds zero", r, 32'h0);

    // R10 clear
    wr(A_CTRL, K_IE);
    wr(A_CLR, 32'hDEAD);
    peek(A_RAW, r); chk("R10 clear raw", r, 32'h0);
    chk("R10 irq_o after clear", 32'(irq_o), 32'h0);

    // R7 wrap in both widths, R9 without interrupt enable
    for (int w = 0; w < 2; w++) begin
      quiet();
      wr(A_LOAD, 32'd1);
      wr(A_CTRL, K_EN | (w == 1 ? K_WIDE : 32'h0));
      edges(1);
      peek(A_RAW, r); chk("R9 raw without enable", r, 32'h1);
      peek(A_MSK, r); chk("R9 masked without enable", r, 32'h0);
      chk("R9 irq_o without enable", 32'(irq_o), 32'h0);
      edges(1);
      peek(A_VAL, r); chk("R7 wrap to all ones", r, (w == 1) ? 32'hFFFF_FFFF : 32'h0000_FFFF);
      edges(1);
      peek(A_VAL, r); chk("R7 count after wrap", r, (w == 1) ? 32'hFFFF_FFFE : 32'h0000_FFFE);
    end

    // R11 debug halt
    quiet();
    wr(A_LOAD, 32'd100);
    dbg_halt_i = 1'b1;
    wr(A_CTRL, K_EN | K_HALT | K_PER | K_WIDE);
    edges(10);
    peek(A_VAL, r); chk("R11 halted count frozen", r, 32'd100);
    dbg_halt_i = 1'b0;
    edges(4);
    peek(A_VAL, r); chk("R11 resumes after halt", r, 32'd96);
    wr(A_CTRL, K_EN | K_PER | K_WIDE);
    peek(A_VAL, base);
    dbg_halt_i = 1'b1;
    edges(4);
    peek(A_VAL, r); chk("R11 halt ignored without bit 8", r, base - 32'd4);
    dbg_halt_i = 1'b0;

    // R12 free-running counter
    for (int d = 0; d < 4; d++) begin
      wr(A_CTRL, 32'h0);
      peek(A_FREE, base);
      wr(A_CTRL, K_FREE | 32'(d << 16));
      edges(13);
      peek(A_FREE, r); chk("R12 free count rate", r, base + 32'(13 / (d + 1)));
    end
    wr(A_CTRL, 32'h0);
    peek(A_FREE, f1);
    edges(7);
    peek(A_FREE, r); chk("R12 free holds when off", r, f1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule